// File: doc/BRIEF.md
# DMA Access Protection Fault Monitor

This block watches every memory access issued by a transfer engine and checks it against one or two programmable address windows. Each access comes with its address, its direction and the identity of the control packet that issued it. The packet identity is a channel index and an A/B half. Two checks run in parallel. The single-window check compares the access against window 0 only. The combined check flags an access only when it lies outside both window 0 and window 1. Either check also flags a write when its rights bit allows reads only. A violation sets a sticky fault flag. When the matching interrupt enable is set, the flag drives an interrupt line.

For each check, the monitor records the packet number of the first violation. That record holds until software reads the status word, so later violations do not overwrite it. A status read made outside debug mode re-arms the capture. While the debug input is high, both captured packet numbers stay frozen: a violation does not load them and a read does not re-arm them.

Software programs the block over a simple 32-bit register port with a word index. Control bits and window bounds change only on privileged writes. Fault flags are cleared by a privileged write of 1 to their bit.

Top module: `dma_prot_monitor`

## Requirements
- R1: After reset, every register reads 0, both interrupts are low and both captures are armed.
- R2: When the window-0 enable (status bit 0) is set, an access whose address is below window-0 start (index 1) or above window-0 end (index 2) sets flag 0 (status bit 16). Both bounds are inclusive, so an access on either bound does not set the flag.
- R3: A rights bit of 1 makes its check treat any write as a violation, even inside the window; reads inside the window stay legal. The rights bit is status bit 1 for window 0 and bit 4 for the combined check. A rights bit of 0 permits both directions.
- R4: With its enable bit clear, a check never sets its flag, whatever the access.
- R5: When the combined enable (status bit 3) is set, flag 1 (status bit 17) sets for an access outside both window 0 and window 1 (indices 3 and 4, inclusive). An access inside either window leaves flag 1 clear.
- R6: A privileged write of 1 to a flag bit of the status word (index 0) clears that flag. Writing 0, or writing in user mode, leaves the flag unchanged. A violation in the same cycle as the clear wins, and the flag stays set.
- R7: The six control bits (status bits 5:0) and the four window bounds change only on privileged writes. User-mode writes to them are ignored.
- R8: The captured packet number is 2*channel + half, with half A = 0 and half B = 1. The single-window capture sits in status bits 27:24 and the combined capture in bits 11:8. Each capture holds the first violating packet until the status word is read.
- R9: A status read (bus_rd at index 0) with debug low re-arms both captures. With debug high, the captures neither load nor re-arm. A re-armed capture loads the next violation.
- R10: irq0 is high while flag 0 and its interrupt enable (bit 2) are both set. irq1 is high while flag 1 and its interrupt enable (bit 5) are both set.
- R11: All status bits outside 27:24, 17:16, 11:8 and 5:0 read 0, as do indices 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_chan | input | 3 | Channel index of the issuing packet |
| acc_half | input | 1 | Packet half, 0 = A, 1 = B |
| priv | input | 1 | Register write is privileged |
| dbg | input | 1 | Debug mode, freezes the captures |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (re-arms on index 0) |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq0 | output | 1 | Single-window fault interrupt |
| irq1 | output | 1 | Combined fault interrupt |

## Verification
The bench aims at the window bounds themselves. A design with exclusive or shifted comparisons would flag an access sitting on the start or end address. It sends a second violation before any read; a capture that re-loads would show the later packet number. It reads the status while debug is high and then violates; a design that re-arms or captures in debug would change the recorded number. It also tries user-mode writes, zero-writes and clear-versus-set collisions, where a wrong design would lose a flag or take a forbidden control change.

// File: rtl/dma_prot_monitor.sv
`timescale 1ns/1ps
module dma_prot_monitor #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  input  logic [2:0]    acc_chan,
  input  logic          acc_half,
  input  logic          priv,
  input  logic          dbg,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq0,
  output logic          irq1
);
  localparam int FLAG0 = 16;
  localparam int FLAG1 = 17;

  logic [AW-1:0] lo0_q, hi0_q, lo1_q, hi1_q;
  logic [5:0]    ctrl_q;
  logic          f0_q, f1_q, arm0_q, arm1_q;
  logic [3:0]    cp0_q, cp1_q;

  wire en0 = ctrl_q[0];
  wire rw0 = ctrl_q[1];
  wire ie0 = ctrl_q[2];
  wire en1 = ctrl_q[3];
  wire rw1 = ctrl_q[4];
  wire ie1 = ctrl_q[5];

  wire out0 = (acc_addr < lo0_q) || (acc_addr > hi0_q);
  wire out1 = (acc_addr < lo1_q) || (acc_addr > hi1_q);
  wire viol0 = acc_valid && en0 && (out0 || (rw0 && acc_write));
  wire viol1 = acc_valid && en1 && ((out0 && out1) || (rw1 && acc_write));

  wire [3:0] pkt = {acc_chan, acc_half};
  wire pwr  = bus_wr && priv;
  wire st_w = pwr && (bus_addr == 3'd0);
  wire rearm = bus_rd && (bus_addr == 3'd0) && !dbg;
  wire cap0 = viol0 && arm0_q && !dbg;
  wire cap1 = viol1 && arm1_q && !dbg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo0_q  <= '0;
      hi0_q  <= '0;
      lo1_q  <= '0;
      hi1_q  <= '0;
      ctrl_q <= '0;
      f0_q   <= 1'b0;
      f1_q   <= 1'b0;
      cp0_q  <= '0;
      cp1_q  <= '0;
      arm0_q <= 1'b1;
      arm1_q <= 1'b1;
    end else begin
      if (st_w) ctrl_q <= bus_wdata[5:0];
      if (pwr && bus_addr == 3'd1) lo0_q <= bus_wdata[AW-1:0];
      if (pwr && bus_addr == 3'd2) hi0_q <= bus_wdata[AW-1:0];
      if (pwr && bus_addr == 3'd3) lo1_q <= bus_wdata[AW-1:0];
      if (pwr && bus_addr == 3'd4) hi1_q <= bus_wdata[AW-1:0];

      f0_q <= viol0 || (f0_q && !(st_w && bus_wdata[FLAG0]));
      f1_q <= viol1 || (f1_q && !(st_w && bus_wdata[FLAG1]));

      if (cap0) cp0_q <= pkt;
      if (cap1) cp1_q <= pkt;
      arm0_q <= cap0 ? 1'b0 : (rearm ? 1'b1 : arm0_q);
      arm1_q <= cap1 ? 1'b0 : (rearm ? 1'b1 : arm1_q);
    end
  end

  logic [31:0] status;
  always_comb begin
    status        = '0;
    status[27:24] = cp0_q;
    status[FLAG1] = f1_q;
    status[FLAG0] = f0_q;
    status[11:8]  = cp1_q;
    status[5:0]   = ctrl_q;
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = status;
      3'd1:    bus_rdata = 32'(lo0_q);
      3'd2:    bus_rdata = 32'(hi0_q);
      3'd3:    bus_rdata = 32'(lo1_q);
      3'd4:    bus_rdata = 32'(hi1_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq0 = f0_q && ie0;
  assign irq1 = f1_q && ie1;
endmodule

module dma_prot_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        priv,
  input logic        dbg,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        irq0,
  input logic        irq1,
  input logic [5:0]  ctrl_q,
  input logic        f0_q,
  input logic        f1_q,
  input logic [3:0]  cp0_q,
  input logic [3:0]  cp1_q
);
  a_r4_off_no_flag0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !ctrl_q[0] && !f0_q) |=> !f0_q);
  a_r4_off_no_flag1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !ctrl_q[3] && !f1_q) |=> !f1_q);
  a_r6_flag0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (f0_q && !(bus_wr && priv && bus_addr == 3'd0 && bus_wdata[16])) |=> f0_q);
  a_r6_flag1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (f1_q && !(bus_wr && priv && bus_addr == 3'd0 && bus_wdata[17])) |=> f1_q);
  a_r7_user_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !priv) |=> $stable(ctrl_q));
  a_r9_dbg_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    dbg |=> ($stable(cp0_q) && $stable(cp1_q)));
  a_r10_irq0_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |-> f0_q);
  a_r10_irq1_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |-> f1_q);
endmodule

bind dma_prot_monitor dma_prot_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .priv(priv), .dbg(dbg),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq0(irq0), .irq1(irq1), .ctrl_q(ctrl_q), .f0_q(f0_q), .f1_q(f1_q),
  .cp0_q(cp0_q), .cp1_q(cp1_q)
);

// File: tb/dma_prot_monitor_tb.sv
`timescale 1ns/1ps
module dma_prot_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_chan = '0;
  logic        acc_half = 1'b0;
  logic        priv = 1'b0;
  logic        dbg = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq0, irq1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_prot_monitor #(.AW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_chan(acc_chan), .acc_half(acc_half),
    .priv(priv), .dbg(dbg), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq0(irq0), .irq1(irq1));

  // reference model
  int unsigned m_win[4];
  bit [5:0] m_ctrl;
  bit m_f0, m_f1, m_arm0, m_arm1;
  int m_cp0, m_cp1;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_win[i]) m_win[i] = 0;
      m_ctrl = 0; m_f0 = 0; m_f1 = 0; m_cp0 = 0; m_cp1 = 0;
      m_arm0 = 1; m_arm1 = 1;
    end else begin
      bit in0, in1, v0, v1, clr0, clr1;
      int pk;
      in0 = acc_addr >= m_win[0] && acc_addr <= m_win[1];
      in1 = acc_addr >= m_win[2] && acc_addr <= m_win[3];
      v0 = acc_valid && m_ctrl[0] && (!in0 || (m_ctrl[1] && acc_write));
      v1 = acc_valid && m_ctrl[3] && ((!in0 && !in1) || (m_ctrl[4] && acc_write));
      pk = acc_chan * 2 + acc_half;
      clr0 = bus_wr && priv && bus_addr == 0 && bus_wdata[16];
      clr1 = bus_wr && priv && bus_addr == 0 && bus_wdata[17];
      if (v0 && m_arm0 && !dbg) begin m_cp0 = pk; m_arm0 = 0; end
      else if (bus_rd && bus_addr == 0 && !dbg) m_arm0 = 1;
      if (v1 && m_arm1 && !dbg) begin m_cp1 = pk; m_arm1 = 0; end
      else if (bus_rd && bus_addr == 0 && !dbg) m_arm1 = 1;
      m_f0 = v0 || (m_f0 && !clr0);
      m_f1 = v1 || (m_f1 && !clr1);
      if (bus_wr && priv) begin
        if (bus_addr == 0) m_ctrl = bus_wdata[5:0];
        else if (bus_addr <= 4) m_win[bus_addr-1] = bus_wdata;
      end
    end
  end

  function automatic logic [31:0] exp_rdata(input logic [2:0] a);
    if (a == 0) return (32'(m_cp0) << 24) | (32'(m_f1) << 17) | (32'(m_f0) << 16)
                      | (32'(m_cp1) << 8) | 32'(m_ctrl);
    if (a <= 4) return m_win[a-1];
    return 0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (!done) begin
    logic [31:0] e;
    e = exp_rdata(bus_addr);
    if (bus_addr == 0) begin
      check("R8 cp0", {28'd0, bus_rdata[27:24]}, {28'd0, e[27:24]});
      check("R8 cp1", {28'd0, bus_rdata[11:8]}, {28'd0, e[11:8]});
      check("R2 flags", {30'd0, bus_rdata[17:16]}, {30'd0, e[17:16]});
      check("R7 ctrl", {26'd0, bus_rdata[5:0]}, {26'd0, e[5:0]});
      check("R11 reserved", bus_rdata & 32'hF0FC_F0C0, 32'd0);
    end else check("R7 window", bus_rdata, e);
    check("R10 irq", {30'd0, irq1, irq0},
          {30'd0, m_f1 && m_ctrl[5], m_f0 && m_ctrl[2]});
  end

  task automatic tick();
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d, input logic p);
    bus_wr = 1; bus_addr = a; bus_wdata = d; priv = p;
    tick();
    priv = 0;
  endtask

  task automatic rd_status();
    bus_rd = 1; bus_addr = 0;
    tick();
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic [2:0] ch, input logic h);
    acc_valid = 1; acc_addr = a; acc_write = w; acc_chan = ch; acc_half = h;
    tick();
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata; bus_addr = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < 8; i++) begin peek(3'(i), v); check("R1 reset value", v, 0); end
    check("R1 reset irq", {30'd0, irq1, irq0}, 0);
    rst_n = 1;
    tick();

    // R4: disabled check never flags
    access(32'h9000, 1, 3'd2, 0);
    peek(0, v); check("R4 no flag while disabled", v[17:16], 0);

    // R7: privileged vs user writes
    wreg(1, 32'h100, 1); wreg(2, 32'h1FF, 1);
    wreg(1, 32'h555, 0); wreg(0, 32'h3F, 0);
    peek(1, v); check("R7 user window write ignored", v, 32'h100);
    peek(0, v); check("R7 user ctrl write ignored", v[5:0], 0);

    // R2: inclusive bounds, R8 capture, R10 interrupt
    wreg(0, 32'h05, 1);
    access(32'h100, 1, 3'd0, 0);
    access(32'h1FF, 0, 3'd0, 0);
    peek(0, v); check("R2 bounds inclusive", v[16], 0);
    access(32'h200, 1, 3'd3, 1);
    peek(0, v); check("R2 above end flags", v[16], 1);
    check("R8 first packet ch3 B", v[27:24], 7);
    check("R10 irq0 raised", irq0, 1);
    access(32'h0FF, 0, 3'd1, 0);
    peek(0, v); check("R8 held until read", v[27:24], 7);

    // R9: debug freeze, then re-arm
    dbg = 1; rd_status();
    access(32'h300, 0, 3'd2, 0);
    peek(0, v); check("R9 frozen in debug", v[27:24], 7);
    dbg = 0; rd_status();
    access(32'h050, 0, 3'd5, 0);
    peek(0, v); check("R9 rearmed capture ch5 A", v[27:24], 10);

    // R6: clearing rules
    wreg(0, 32'h05, 1);
    peek(0, v); check("R6 write 0 keeps flag", v[16], 1);
    wreg(0, 32'h0001_0005, 0);
    peek(0, v); check("R6 user clear ignored", v[16], 1);
    wreg(0, 32'h0001_0005, 1);
    peek(0, v); check("R6 privileged clear", v[16], 0);
    check("R10 irq0 dropped", irq0, 0);
    acc_valid = 1; acc_addr = 32'h700; acc_write = 0;
    wreg(0, 32'h0001_0005, 1);
    peek(0, v); check("R6 set wins over clear", v[16], 1);
    wreg(0, 32'h0001_0005, 1);

    // R3: read-only rights
    wreg(0, 32'h07, 1);
    access(32'h180, 0, 3'd4, 0);
    peek(0, v); check("R3 read inside legal", v[16], 0);
    access(32'h180, 1, 3'd4, 1);
    peek(0, v); check("R3 write inside violates", v[16], 1);
    wreg(0, 32'h0001_0000, 1);

    // R5: combined check
    wreg(3, 32'h400, 1); wreg(4, 32'h4FF, 1);
    rd_status();
    wreg(0, 32'h28, 1);
    access(32'h450, 1, 3'd6, 0);
    access(32'h150, 1, 3'd6, 0);
    peek(0, v); check("R5 inside either window legal", v[17], 0);
    access(32'h300, 0, 3'd6, 1);
    peek(0, v); check("R5 outside both flags", v[17], 1);
    check("R8 combined capture ch6 B", v[11:8], 13);
    check("R10 irq1 raised", irq1, 1);
    wreg(0, 32'h38, 1);
    wreg(0, 32'h0002_0038, 1);
    access(32'h450, 1, 3'd0, 0);
    peek(0, v); check("R3 combined read-only write", v[17], 1);

    // R11: reserved bits and unused indices
    wreg(0, 32'hFFFF_FFFF, 1);
    peek(0, v); check("R11 reserved zero", v & 32'hF0FC_F0C0, 0);
    peek(6, v); check("R11 unused index", v, 0);

    tick(); tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule